// File: doc/BRIEF.md
# LED Matrix Display Mode Selector

This block decides what reaches a 16 by 16 RGB LED matrix. The matrix side has 64 lines: 16 row-supply enables and, for each of red, green and blue, 16 column-sink enables. Two sources compete for them. One is a 64-bit frame written by a processor-driven register chain. The other is a 48-bit level-meter input made of three 16-bit thermometer codes for the low, middle and high frequency bands. A 2-bit mode select chooses between them.

In the two bargraph modes, the row enables still come from the processor frame. The column enables come from the level meter. Each frequency band drives only the columns of its own colour: low drives blue, middle drives green and high drives red. Every pair of thermometer bits lights a mirrored pair of columns. The bar grows either from the centre outwards or from both edges inwards. A colour stays dark when no row of its band is enabled. The rows are split into three bands: the bottom six are blue, the next six are green and the top four are red.

The mode select and all outputs are captured only on a frame strobe. A mode change therefore lands on a frame boundary, and the output never changes in the middle of a frame.

Top module: `lmx_mode_select`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, every output is 0.
- R2: `row_en`, `col_red`, `col_grn`, `col_blu` and `eq_active` change only on the clock edge at which `frame_stb` is 1. The new values are visible after that edge. Without a strobe, they hold even when the inputs change.
- R3: In mode 0 (`mode_sel`=2'b00, direct), the bus `cpu_frame` is passed through as follows: bits [15:0] go to `row_en`, bits [31:16] go to `col_red`, bits [47:32] go to `col_grn` and bits [63:48] go to `col_blu`.
- R4: Mode 3 (2'b11, equalizer) passes the frame through exactly as in mode 0 and sets `eq_active` to 1.
- R5: In mode 1 (2'b01) and mode 2 (2'b10), `row_en` equals `cpu_frame[15:0]`.
- R6: In mode 1 (centre-out), level bits 2j and 2j+1 of a band are ORed, and the result lights columns 7−j and 8+j, for j from 0 to 7.
- R7: In mode 2 (edge-in), level bits 2j and 2j+1 of a band are ORed, and the result lights columns j and 15−j.
- R8: In the bargraph modes, `level_in[15:0]` (low band) drives `col_blu`, `level_in[31:16]` (middle band) drives `col_grn` and `level_in[47:32]` (high band) drives `col_red`.
- R9: In the bargraph modes, `col_blu` is 0 when `cpu_frame[5:0]` is all 0, `col_grn` is 0 when `cpu_frame[11:6]` is all 0, and `col_red` is 0 when `cpu_frame[15:12]` is all 0.
- R10: `eq_active` is 0 after a strobe in any mode other than 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | Frame boundary; captures mode and outputs |
| mode_sel | input | 2 | 0 direct, 1 centre-out bar, 2 edge-in bar, 3 equalizer |
| cpu_frame | input | 64 | Processor frame: rows, red, green, blue |
| level_in | input | 48 | Thermometer levels: low, middle, high band |
| row_en | output | 16 | Row-supply enables |
| col_red | output | 16 | Red column-sink enables |
| col_grn | output | 16 | Green column-sink enables |
| col_blu | output | 16 | Blue column-sink enables |
| eq_active | output | 1 | Equalizer mode in force |

## Verification
The hardest case to reach is a colour blanked by its row band while its level input is non-zero. In the middle of such a frame the inputs also change without a strobe. The stimulus drives full-scale levels on all three bands and enables rows in only one band at a time, so two colours must read 0 while the third shows a bar. It then alters every input for several cycles with the strobe held low, and the outputs must keep the captured frame.

// File: rtl/lmx_pkg.sv
package lmx_pkg;
  typedef enum logic [1:0] {
    MODE_DIRECT  = 2'b00,
    MODE_BAR_CTR = 2'b01,
    MODE_BAR_EDG = 2'b10,
    MODE_EQ      = 2'b11
  } lmx_mode_e;

  function automatic logic is_bar(input logic [1:0] m);
    return (m == MODE_BAR_CTR) || (m == MODE_BAR_EDG);
  endfunction
endpackage

// File: rtl/lmx_bar_map.sv
// Maps one band's thermometer code onto mirrored column pairs.
module lmx_bar_map #(
  parameter int COLS       = 16,
  parameter bit CENTRE_OUT = 1'b1
) (
  input  logic [COLS-1:0] level,
  output logic [COLS-1:0] cols
);
  localparam int HALF = COLS / 2;

  for (genvar j = 0; j < HALF; j++) begin : g_pair
    logic lit;
    assign lit = level[2*j] | level[2*j+1];
    if (CENTRE_OUT) begin : g_ctr
      assign cols[HALF-1-j] = lit;
      assign cols[HALF+j]   = lit;
    end else begin : g_edg
      assign cols[j]        = lit;
      assign cols[COLS-1-j] = lit;
    end
  end
endmodule

// File: rtl/lmx_band_gate.sv
// Reports whether any row inside [LO, HI] is enabled.
module lmx_band_gate #(
  parameter int ROWS = 16,
  parameter int LO   = 0,
  parameter int HI   = 5
) (
  input  logic [ROWS-1:0] rows,
  output logic            any_on
);
  always_comb begin
    any_on = 1'b0;
    for (int r = LO; r <= HI; r++) any_on = any_on | rows[r];
  end
endmodule

// File: rtl/lmx_mode_select.sv
module lmx_mode_select #(
  parameter int ROWS       = 16,
  parameter int COLS       = 16,
  parameter int BLUE_ROWS  = 6,
  parameter int GREEN_ROWS = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 frame_stb,
  input  logic [1:0]           mode_sel,
  input  logic [ROWS+3*COLS-1:0] cpu_frame,
  input  logic [3*COLS-1:0]    level_in,
  output logic [ROWS-1:0]      row_en,
  output logic [COLS-1:0]      col_red,
  output logic [COLS-1:0]      col_grn,
  output logic [COLS-1:0]      col_blu,
  output logic                 eq_active
);
  import lmx_pkg::*;

  localparam int BANDS  = 3;
  localparam int GRN_LO = BLUE_ROWS;
  localparam int RED_LO = BLUE_ROWS + GREEN_ROWS;

  // band index: 0 low/blue, 1 middle/green, 2 high/red
  logic [COLS-1:0] ctr_cols [BANDS];
  logic [COLS-1:0] edg_cols [BANDS];
  logic [BANDS-1:0] band_on;

  for (genvar g = 0; g < BANDS; g++) begin : g_band
    lmx_bar_map #(.COLS(COLS), .CENTRE_OUT(1'b1)) i_ctr (
      .level(level_in[g*COLS +: COLS]), .cols(ctr_cols[g]));
    lmx_bar_map #(.COLS(COLS), .CENTRE_OUT(1'b0)) i_edg (
      .level(level_in[g*COLS +: COLS]), .cols(edg_cols[g]));
  end

  lmx_band_gate #(.ROWS(ROWS), .LO(0), .HI(GRN_LO-1)) i_gate_blu (
    .rows(cpu_frame[ROWS-1:0]), .any_on(band_on[0]));
  lmx_band_gate #(.ROWS(ROWS), .LO(GRN_LO), .HI(RED_LO-1)) i_gate_grn (
    .rows(cpu_frame[ROWS-1:0]), .any_on(band_on[1]));
  lmx_band_gate #(.ROWS(ROWS), .LO(RED_LO), .HI(ROWS-1)) i_gate_red (
    .rows(cpu_frame[ROWS-1:0]), .any_on(band_on[2]));

  logic [COLS-1:0] nxt_red, nxt_grn, nxt_blu;
  logic [COLS-1:0] bar_sel [BANDS];

  always_comb begin
    for (int g = 0; g < BANDS; g++) begin
      bar_sel[g] = (mode_sel == MODE_BAR_CTR) ? ctr_cols[g] : edg_cols[g];
      if (!band_on[g]) bar_sel[g] = '0;
    end
    if (is_bar(mode_sel)) begin
      nxt_blu = bar_sel[0];
      nxt_grn = bar_sel[1];
      nxt_red = bar_sel[2];
    end else begin
      nxt_red = cpu_frame[ROWS +: COLS];
      nxt_grn = cpu_frame[ROWS+COLS +: COLS];
      nxt_blu = cpu_frame[ROWS+2*COLS +: COLS];
    end
  end

  logic [1:0] mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MODE_DIRECT;
      row_en  <= '0;
      col_red <= '0;
      col_grn <= '0;
      col_blu <= '0;
    end else if (frame_stb) begin
      mode_q  <= mode_sel;
      row_en  <= cpu_frame[ROWS-1:0];
      col_red <= nxt_red;
      col_grn <= nxt_grn;
      col_blu <= nxt_blu;
    end
  end

  assign eq_active = (mode_q == MODE_EQ);

  function automatic logic [COLS-1:0] mirror(input logic [COLS-1:0] v);
    for (int i = 0; i < COLS; i++) mirror[i] = v[COLS-1-i];
  endfunction

  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (row_en == '0 && col_red == '0 && eq_active == 1'b0)); // R1
  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    !$past(frame_stb) && !$past(rst) |-> $stable(row_en) && $stable(col_blu) && $stable(eq_active)); // R2
  AST_DIRECT_ROWS: assert property (@(posedge clk) disable iff (rst)
    $past(frame_stb) && !$past(rst) |-> row_en == $past(cpu_frame[ROWS-1:0])); // R5
  AST_BAR_MIRROR: assert property (@(posedge clk) disable iff (rst)
    $past(frame_stb) && !$past(rst) && is_bar($past(mode_sel))
    |-> col_red == mirror(col_red) && col_blu == mirror(col_blu)); // R6
  AST_BLUE_BLANK: assert property (@(posedge clk) disable iff (rst)
    $past(frame_stb) && !$past(rst) && is_bar($past(mode_sel)) && $past(cpu_frame[GRN_LO-1:0]) == '0
    |-> col_blu == '0); // R9
  AST_EQ_FLAG: assert property (@(posedge clk) disable iff (rst)
    $past(frame_stb) && !$past(rst) |-> eq_active == ($past(mode_sel) == MODE_EQ)); // R10
endmodule

// File: tb/test_lmx_mode_select.sv
module test_lmx_mode_select;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_stb = 1'b0;
  logic [1:0]  mode_sel = 2'b00;
  logic [63:0] cpu_frame = '0;
  logic [47:0] level_in = '0;
  logic [15:0] row_en, col_red, col_grn, col_blu;
  logic        eq_active;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  typedef struct packed {
    logic [15:0] rows, red, grn, blu;
    logic        eq;
  } exp_t;
  exp_t exp_q[$];
  exp_t last_exp;

  always #5 clk = ~clk;

  lmx_mode_select i_lmx_mode_select (
    .clk(clk), .rst(rst), .frame_stb(frame_stb), .mode_sel(mode_sel),
    .cpu_frame(cpu_frame), .level_in(level_in), .row_en(row_en),
    .col_red(col_red), .col_grn(col_grn), .col_blu(col_blu), .eq_active(eq_active));

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] bar(input logic [15:0] lvl, input bit centre);
    logic [15:0] r;
    for (int c = 0; c < 16; c++) begin
      int d;
      if (centre) d = (c < 8) ? 7 - c : c - 8;
      else        d = (c < 8) ? c : 15 - c;
      r[c] = lvl[2*d] | lvl[2*d+1];
    end
    return r;
  endfunction

  function automatic exp_t model(input logic [1:0] m, input logic [63:0] f, input logic [47:0] l);
    exp_t e;
    e.rows = f[15:0];
    e.eq = (m == 2'b11);
    if (m == 2'b01 || m == 2'b10) begin
      e.blu = (|f[5:0])   ? bar(l[15:0],  m == 2'b01) : '0;
      e.grn = (|f[11:6])  ? bar(l[31:16], m == 2'b01) : '0;
      e.red = (|f[15:12]) ? bar(l[47:32], m == 2'b01) : '0;
    end else begin
      e.red = f[31:16]; e.grn = f[47:32]; e.blu = f[63:48];
    end
    return e;
  endfunction

  // Driver: one strobed frame, expectation pushed to scoreboard
  task automatic send(input logic [1:0] m, input logic [63:0] f, input logic [47:0] l);
    @(negedge clk);
    mode_sel = m; cpu_frame = f; level_in = l; frame_stb = 1'b1;
    exp_q.push_back(model(m, f, l));
    @(negedge clk);
    frame_stb = 1'b0;
    mode_sel = ~m; cpu_frame = ~f; level_in = ~l;
    @(negedge clk);
  endtask

  // Monitor: compares one cycle after each strobed edge
  initial begin
    forever begin
      @(posedge clk);
      if (frame_stb && !rst) begin
        exp_t e;
        #1;
        e = exp_q.pop_front();
        last_exp = e;
        chk(row_en == e.rows, "R3/R5 rows", row_en, e.rows);
        chk(col_red == e.red, "R3/R6/R7/R8/R9 red", col_red, e.red);
        chk(col_grn == e.grn, "R3/R6/R7/R8/R9 green", col_grn, e.grn);
        chk(col_blu == e.blu, "R3/R6/R7/R8/R9 blue", col_blu, e.blu);
        chk(eq_active == e.eq, "R4/R10 eq flag", {15'b0, eq_active}, {15'b0, e.eq});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(row_en == 0 && col_red == 0 && col_grn == 0 && col_blu == 0 && !eq_active,
        "R1 reset outputs", row_en | col_red | col_blu, 16'h0);
    rst = 1'b0;
    @(negedge clk);
    chk(row_en == 0 && col_blu == 0 && !eq_active, "R1 after reset", row_en, 16'h0);

    send(2'b00, 64'h1234_5678_9ABC_DEF0, 48'hFFFF_FFFF_FFFF); // R3 R10
    send(2'b11, 64'hA5A5_0F0F_C3C3_FFFF, 48'h0);              // R4
    send(2'b01, 64'h0000_0000_0000_FFFF, 48'h00FF_0003_000F); // R6 R8
    send(2'b10, 64'h0000_0000_0000_FFFF, 48'h00FF_0003_000F); // R7 R8
    send(2'b01, 64'hFFFF_FFFF_FFFF_FFFF, 48'h0001_FFFF_0000); // R6 odd and full
    send(2'b10, 64'h0000_0000_0000_8421, 48'h7FFF_0002_0100); // R7
    send(2'b01, 64'hFFFF_FFFF_FFFF_0003, 48'hFFFF_FFFF_FFFF); // R9 blue band only
    send(2'b10, 64'h0000_0000_0000_F000, 48'hFFFF_FFFF_FFFF); // R9 red band only
    send(2'b01, 64'h0000_0000_0000_0040, 48'hFFFF_FFFF_FFFF); // R9 green band only
    send(2'b01, 64'h0000_0000_0000_0000, 48'hFFFF_FFFF_FFFF); // R9 all blank
    send(2'b00, 64'hFEDC_BA98_7654_3210, 48'h0);              // R3 R10 back to direct

    // R2: inputs move, strobe held low, outputs hold the last frame
    send(2'b11, 64'h1111_2222_3333_4444, 48'h0);
    @(negedge clk);
    mode_sel = 2'b01; cpu_frame = 64'h0; level_in = 48'hFFFF_FFFF_FFFF;
    repeat (4) @(negedge clk);
    chk(row_en == last_exp.rows, "R2 hold rows", row_en, last_exp.rows);
    chk(col_red == last_exp.red && col_grn == last_exp.grn && col_blu == last_exp.blu,
        "R2 hold columns", col_blu, last_exp.blu);
    chk(eq_active == 1'b1, "R2 hold eq flag", {15'b0, eq_active}, 16'h1);

    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "scoreboard drained", 16'(exp_q.size()), 16'h0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule